// File: doc/BRIEF.md
# Multichannel Ratio-Selectable Deserializer

This block turns a set of serial lanes into parallel words. All lanes are sampled on one fast bit clock. A slow frame clock arrives as a single-cycle pulse in the fast domain and marks where each word starts. The fast clock runs at N times the frame rate, where N is the selected ratio: 8, 7, 4 or 1 bits per word. Each lane builds its word from the bits sampled between two frame pulses. On the next pulse the word moves into a holding register, and a shared strobe marks it as new for one cycle.

The ratio can change at run time. A new ratio takes effect only at a frame pulse. The first word built under the new ratio is dropped, because the frame pulse spacing may still be settling. Any lane can be switched to pass-through. Its serial bit then comes out on a separate output one cycle later, and its parallel word is held at zero. Words are formed only from full frames. A frame pulse that comes early ends the word under construction without delivering it.

Top module: `mlane_deser`

## Requirements
- R1: In 8:1 mode (ratio code 2'b00), word bit k of a lane equals the bit sampled on that lane k cycles after the cycle in which the frame pulse is high. Bit 0 is sampled in the pulse cycle itself.
- R2: In 7:1 mode (code 2'b01) and 4:1 mode (code 2'b10), the low 7 or 4 bits are built as in R1. All higher word bits read zero.
- R3: In 1:1 mode (code 2'b11), with a frame pulse on every cycle, a new word arrives every cycle. Its bit 0 is the bit sampled in the previous cycle, and bits 7..1 read zero.
- R4: A full frame is delivered one cycle after the frame pulse that ends it. The valid strobe is high for exactly that cycle. The parallel output holds its value until the next delivery.
- R5: A frame pulse that arrives before N bits have been collected produces no valid strobe and leaves the parallel output unchanged. The frame pulse after reset delivers nothing, and bits sampled before it are not used.
- R6: A change of the ratio select takes effect at the next frame pulse. A word already in progress completes under the old ratio and is delivered. The first word collected under the new ratio is discarded.
- R7: For a lane with its bypass bit set, the bypass output equals that lane's serial input one cycle earlier, and its parallel word is delivered as zero. For other lanes the bypass output is zero.
- R8: While reset is high and after it, the valid strobe, all parallel words and all bypass outputs read zero until new data is delivered.
- R9: All 16 lanes convert independently. Distinct data on every lane is delivered to that lane's own 8-bit slice (lane l occupies bits 8l+7..8l).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_en | input | 1 | Frame pulse in the fast domain, high in the cycle of bit 0 |
| ratio_sel | input | 2 | Ratio code: 00 = 8:1, 01 = 7:1, 10 = 4:1, 11 = 1:1 |
| bypass | input | 16 | Per-lane pass-through select |
| ser_in | input | 16 | Serial data, one bit per lane |
| par_out | output | 128 | Parallel words, lane l in bits 8l+7..8l |
| word_valid | output | 1 | Single-cycle strobe for a new set of words |
| byp_out | output | 16 | Registered serial bit of lanes in pass-through |

## Verification
Words are sent in each ratio with all-zero, all-one, alternating and walking-one patterns, plus random data that differs per lane. These separate bit-order mistakes, stuck bits and lane swaps. Random 8-bit data is also sent in the shorter modes, so any bit captured beyond N shows up as a nonzero upper bit. Ratio changes are made both mid-frame and at a frame pulse. This shows whether the old word is still delivered and the first new word dropped. An early frame pulse and a late bypass switch check that an incomplete frame leaves the held words untouched, and that pass-through lanes deliver zero while echoing their serial bit.

// File: rtl/deser_pkg.sv
`timescale 1ns/1ps
package deser_pkg;
    localparam int WORD_W = 8;
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int IDX_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_IDLE = {CNT_W{1'b1}};

    typedef enum logic [1:0] {
        RATIO_8 = 2'b00,
        RATIO_7 = 2'b01,
        RATIO_4 = 2'b10,
        RATIO_1 = 2'b11
    } ratio_e;

    // Bits per word for a ratio code.
    function automatic logic [CNT_W-1:0] ratio_len(input ratio_e r);
        logic [CNT_W-1:0] n;
        case (r)
            RATIO_8: n = CNT_W'(WORD_W);
            RATIO_7: n = CNT_W'(WORD_W - 1);
            RATIO_4: n = CNT_W'(WORD_W / 2);
            default: n = CNT_W'(1);
        endcase
        return n;
    endfunction

    // Mask with the low n bits set.
    function automatic logic [WORD_W-1:0] len_mask(input logic [CNT_W-1:0] n);
        logic [WORD_W-1:0] m;
        for (int i = 0; i < WORD_W; i++) begin
            m[i] = (CNT_W'(i) < n);
        end
        return m;
    endfunction
endpackage

// File: rtl/deser_frame_ctl.sv
`timescale 1ns/1ps
module deser_frame_ctl
    import deser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_en,
    input  logic [1:0]        ratio_sel,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              xfer,
    output logic              valid,
    output logic [WORD_W-1:0] keep_mask
);
    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        ratio_e            act;
        logic              skip;
        logic              valid;
        logic [WORD_W-1:0] mask;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic [CNT_W-1:0] len_q;
    logic xfer_c;

    always_comb begin
        st_d   = st_q;
        len_q  = ratio_len(st_q.act);
        xfer_c = 1'b0;
        if (frame_en) begin
            xfer_c     = (st_q.cnt == len_q) && !st_q.skip;
            st_d.valid = xfer_c;
            if (xfer_c) begin
                st_d.mask = len_mask(len_q);
            end
            st_d.skip = (ratio_e'(ratio_sel) != st_q.act);
            st_d.act  = ratio_e'(ratio_sel);
            st_d.cnt  = CNT_W'(1);
        end else begin
            st_d.valid = 1'b0;
            if (st_q.cnt < len_q) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= CNT_IDLE;
            st_q.act   <= RATIO_8;
            st_q.skip  <= 1'b0;
            st_q.valid <= 1'b0;
            st_q.mask  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cap_en    = frame_en || (st_q.cnt < len_q);
    assign cap_idx   = frame_en ? '0 : st_q.cnt[IDX_W-1:0];
    assign xfer      = xfer_c;
    assign valid     = st_q.valid;
    assign keep_mask = st_q.mask;

    // R4: a strobe only ever follows a frame pulse
    a_r4_valid_after_pulse: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(frame_en));

    // R6: the active ratio moves only on a frame pulse
    a_r6_ratio_held: assert property (@(posedge clk) disable iff (rst)
        !frame_en |=> $stable(st_q.act));

    // R6: the word after a ratio change is never delivered
    a_r6_skip_drops: assert property (@(posedge clk) disable iff (rst)
        (frame_en && st_q.skip) |=> !valid);

    // R5: the bit counter stays inside the frame or idles
    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt <= len_q) || (st_q.cnt == CNT_IDLE));
endmodule

// File: rtl/deser_lane.sv
`timescale 1ns/1ps
module deser_lane
    import deser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_en,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic              xfer,
    input  logic [WORD_W-1:0] keep_mask,
    input  logic              bypass,
    input  logic              ser_in,
    output logic [WORD_W-1:0] word_o,
    output logic              byp_o
);
    typedef struct packed {
        logic [WORD_W-1:0] asm_w;
        logic [WORD_W-1:0] hold;
        logic              byp;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_en) begin
            st_d.asm_w = '0;
        end
        if (cap_en) begin
            st_d.asm_w[cap_idx] = ser_in;
        end
        if (xfer) begin
            st_d.hold = bypass ? '0 : st_q.asm_w;
        end
        st_d.byp = bypass & ser_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o = st_q.hold;
    assign byp_o  = st_q.byp;

    // R4: held word changes only on a transfer
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(st_q.hold));

    // R2: bits above the delivered ratio read zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (st_q.hold & ~keep_mask) == '0);

    // R7: a pass-through lane delivers a zero word
    a_r7_bypass_zero: assert property (@(posedge clk) disable iff (rst)
        (bypass && xfer) |=> (st_q.hold == '0));

    // R8: reset clears the lane outputs
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (st_q.hold == '0) && !st_q.byp);
endmodule

// File: rtl/mlane_deser.sv
`timescale 1ns/1ps
module mlane_deser
    import deser_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     frame_en,
    input  logic [1:0]               ratio_sel,
    input  logic [LANES-1:0]         bypass,
    input  logic [LANES-1:0]         ser_in,
    output logic [LANES*WORD_W-1:0]  par_out,
    output logic                     word_valid,
    output logic [LANES-1:0]         byp_out
);
    logic              cap_en;
    logic [IDX_W-1:0]  cap_idx;
    logic              xfer;
    logic              valid;
    logic [WORD_W-1:0] keep_mask;

    deser_frame_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .frame_en  (frame_en),
        .ratio_sel (ratio_sel),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .xfer      (xfer),
        .valid     (valid),
        .keep_mask (keep_mask)
    );

    // R9: one independent converter per lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        deser_lane u_lane (
            .clk       (clk),
            .rst       (rst),
            .frame_en  (frame_en),
            .cap_en    (cap_en),
            .cap_idx   (cap_idx),
            .xfer      (xfer),
            .keep_mask (keep_mask),
            .bypass    (bypass[l]),
            .ser_in    (ser_in[l]),
            .word_o    (par_out[l*WORD_W +: WORD_W]),
            .byp_o     (byp_out[l])
        );
    end

    assign word_valid = valid;

    // R8: no strobe in the cycle after reset
    a_r8_no_valid_after_reset: assert property (@(posedge clk)
        rst |=> !word_valid);
endmodule

// File: tb/mlane_deser_tb.sv
`timescale 1ns/1ps
module mlane_deser_tb;
    localparam int LN = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            frame_en = 1'b0;
    logic [1:0]      ratio_sel = 2'b00;
    logic [LN-1:0]   bypass = '0;
    logic [LN-1:0]   ser_in = '0;
    logic [LN*8-1:0] par_out;
    logic            word_valid;
    logic [LN-1:0]   byp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    logic [LN*8-1:0] exp_q[$];
    string           tag_q[$];
    logic [LN*8-1:0] last_word = '0;

    always #2.5 clk = ~clk;

    mlane_deser u_dut (
        .clk        (clk),
        .rst        (rst),
        .frame_en   (frame_en),
        .ratio_sel  (ratio_sel),
        .bypass     (bypass),
        .ser_in     (ser_in),
        .par_out    (par_out),
        .word_valid (word_valid),
        .byp_out    (byp_out)
    );

    // Driver: one frame of nb bits; pushes the expected word when it should be delivered.
    task automatic drive_frame(input int nb, input logic [1:0] sel0, input logic [1:0] sel1,
                               input bit keep, input string tag, input int pat);
        logic [7:0]      dat[LN];
        logic [LN*8-1:0] exp_w;
        logic [7:0]      m;
        m = (nb >= 8) ? 8'hFF : 8'((1 << nb) - 1);
        for (int l = 0; l < LN; l++) begin
            case (pat)
                0: dat[l] = 8'h00;
                1: dat[l] = 8'hFF;
                2: dat[l] = 8'h55 ^ 8'(l);
                3: dat[l] = 8'(1 << (l % 8));
                default: dat[l] = 8'($urandom);
            endcase
            exp_w[l*8 +: 8] = bypass[l] ? 8'h00 : (dat[l] & m);
        end
        if (keep) begin
            exp_q.push_back(exp_w);
            tag_q.push_back(tag);
        end
        for (int c = 0; c < nb; c++) begin
            @(negedge clk);
            frame_en = (c == 0);
            if (c == 0) ratio_sel = sel0;
            if (c == 1) ratio_sel = sel1;
            for (int l = 0; l < LN; l++) ser_in[l] = dat[l][c];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_en = 1'b0;
            ser_in   = '0;
        end
    endtask

    // Monitor: compares delivered words against the scoreboard and checks pass-through.
    initial begin
        logic [LN-1:0] exp_b;
        forever begin
            @(posedge clk);
            exp_b = ser_in & bypass;
            #1;
            if (mon_on) begin
                checks++;
                if (byp_out !== exp_b) begin
                    errors++;
                    $display("FAIL R7 bypass out: actual %h expected %h", byp_out, exp_b);
                end
                if (word_valid) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R6 unexpected word: actual %h expected no word", par_out);
                    end else begin
                        logic [LN*8-1:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (par_out !== e) begin
                            errors++;
                            $display("FAIL %s word: actual %h expected %h", t, par_out, e);
                        end
                    end
                    last_word = par_out;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R4 watchdog: actual 100000 cycles expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: outputs clear during reset
        checks++;
        if (word_valid !== 1'b0 || par_out !== '0 || byp_out !== '0) begin
            errors++;
            $display("FAIL R8 reset state: actual v=%b w=%h b=%h expected 0", word_valid, par_out, byp_out);
        end
        rst = 1'b0;
        // stray bits before the first frame pulse (R5)
        ser_in = 16'hFFFF;
        @(negedge clk);
        checks++;
        if (word_valid !== 1'b0 || par_out !== '0) begin
            errors++;
            $display("FAIL R8 after reset: actual v=%b w=%h expected 0", word_valid, par_out);
        end
        mon_on = 1'b1;
        idle(10);

        // R1 / R9: 8:1 patterns
        drive_frame(8, 2'b00, 2'b00, 1, "R1", 0);
        drive_frame(8, 2'b00, 2'b00, 1, "R1", 1);
        drive_frame(8, 2'b00, 2'b00, 1, "R9", 2);
        drive_frame(8, 2'b00, 2'b00, 1, "R9", 3);
        for (int i = 0; i < 4; i++) drive_frame(8, 2'b00, 2'b00, 1, "R1", 4);

        // R6: mid-frame change to 7:1, old word still delivered, first new dropped
        drive_frame(8, 2'b00, 2'b01, 1, "R6", 4);
        drive_frame(7, 2'b01, 2'b01, 0, "R6", 4);
        for (int i = 0; i < 4; i++) drive_frame(7, 2'b01, 2'b01, 1, "R2", 4);
        drive_frame(7, 2'b01, 2'b01, 1, "R2", 1);

        // R2: 4:1
        drive_frame(4, 2'b10, 2'b10, 0, "R6", 4);
        drive_frame(4, 2'b10, 2'b10, 1, "R2", 1);
        for (int i = 0; i < 4; i++) drive_frame(4, 2'b10, 2'b10, 1, "R2", 4);

        // R3: 1:1
        drive_frame(1, 2'b11, 2'b11, 0, "R6", 4);
        for (int i = 0; i < 12; i++) drive_frame(1, 2'b11, 2'b11, 1, "R3", 4);
        drive_frame(1, 2'b11, 2'b11, 1, "R3", 1);

        // back to 8:1
        drive_frame(8, 2'b00, 2'b00, 0, "R6", 4);
        drive_frame(8, 2'b00, 2'b00, 1, "R1", 4);

        // R5: early frame pulse drops the partial word
        drive_frame(3, 2'b00, 2'b00, 0, "R5", 4);
        // R7: bypass on half the lanes
        @(negedge clk);
        bypass = 16'h0F0F;
        frame_en = 1'b0;
        drive_frame(8, 2'b00, 2'b00, 1, "R7", 1);
        for (int i = 0; i < 3; i++) drive_frame(8, 2'b00, 2'b00, 1, "R7", 4);
        // flush with a final pulse and a dropped one-bit frame
        drive_frame(1, 2'b00, 2'b00, 0, "R4", 4);
        idle(12);

        // R5 / R4: held word kept after the last delivery
        checks++;
        if (par_out !== last_word) begin
            errors++;
            $display("FAIL R5 hold kept: actual %h expected %h", par_out, last_word);
        end
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 words missing: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule